// File: doc/BRIEF.md
# Dual Word FIFO with Flush and Trigger Levels

This block holds two word queues that sit between a register port and a byte-serial engine. Software writes 32-bit words into a transmit queue through a fixed port register. The engine takes those words apart one byte at a time, lowest byte first. On the receive side the engine hands in bytes, the block packs them into words lowest byte first, and software pulls the finished words out through a second port register. A short word ends early when the engine marks a byte as the last one. Only the low bytes of that word are meaningful, and the high bytes read back as zero.

Each direction has a fill count, a flush control that clears itself and a three-bit trigger level. The trigger level decides when that direction's data-request line is raised. One level register packs the free transmit slots and the filled receive slots into a single word. A flag register holds the two data requests, plus sticky flags for a write to a full transmit queue and a read from an empty receive queue. The register read path is combinational. Side effects such as push, pop, flag setting and flush arming take place at the clock edge during which the strobe is high.

Top module: `word_fifo_pair`

## Requirements
- R1: Out of reset the control register reads 0x00, the level register reads 0x80 and the flag register reads 0x02. At this point the transmit data-request pin is 1 and the receive pin is 0.
- R2: Words written to the transmit port (address 3) come out on the byte side in the order they were written. Each word gives its bytes least-significant first. A byte is consumed on a clock edge where both txByteValid and txByteTake are high. After the fourth byte the next word follows.
- R3: Taking a byte while txLast is high discards the rest of that word, so the next byte comes from the next word.
- R4: Received bytes fill a word least-significant byte first. A word is queued after its fourth byte, or earlier on a byte with rxLast high, and unfilled upper bytes are zero. Reads of the receive port (address 4) return the words in the order they were completed.
- R5: In the level register (address 1), bits 7:4 give the number of free transmit slots and bits 3:0 give the number of filled receive slots. With the default depth this is 8 words per direction.
- R6: A write to the control register (address 0) with bit 1 set flushes the transmit queue, and with bit 0 set flushes the receive queue. The bit reads back as 1 until the flush has taken place on the next edge, then as 0. The flush empties only its own queue, including any partly taken or partly packed word, and it leaves the trigger fields as written.
- R7: The transmit trigger level is control bits 7:5. The transmit data request (flag bit 1 and pin txDataReq) is high exactly when the free transmit slots are at least the trigger level plus one.
- R8: The receive trigger level is control bits 4:2. The receive data request (flag bit 0 and pin rxDataReq) is high exactly when the filled receive slots are at least the trigger level plus one.
- R9: A write to the transmit port while it has no free slot discards the word and sets flag bit 5. The flag stays set until a write to the flag register (address 2) with bit 5 set.
- R10: A read of the receive port while it is empty returns 0, leaves the count unchanged and sets flag bit 4. The flag stays set until a write to the flag register with bit 4 set.
- R11: rxByteReady is low exactly while the receive queue is full, and no byte is accepted then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops on the receive port) |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| txDataReq | output | 1 | Transmit data request |
| rxDataReq | output | 1 | Receive data request |
| txByte | output | 8 | Current transmit byte |
| txByteValid | output | 1 | A transmit byte is available |
| txByteTake | input | 1 | Byte engine consumes txByte |
| txLast | input | 1 | The consumed byte ends its word |
| rxByte | input | 8 | Received byte |
| rxByteValid | input | 1 | rxByte is offered |
| rxLast | input | 1 | The offered byte ends its word |
| rxByteReady | output | 1 | The receive side can accept a byte |

## Verification
The transmit path is run with continuous draining, and each consumed byte is compared against a queue of expected bytes. Runs of full words show the byte order and the word order. A short word placed between full words shows that the leftover bytes are dropped and not sent. Trigger behaviour is checked by filling the transmit queue one word at a time with draining stopped, so that the request is seen to turn off exactly at the programmed boundary. The queue is then filled past full to raise the overflow flag. On the receive side the bench sends full words, short words, a partial word cut off by a flush, and a burst that fills the queue. These cases separate lane packing from zero fill, show that the flush clears the packing state, and show the back-pressure at full.

// File: rtl/wfifo_pkg.sv
package wfifo_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_LEVEL  = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_FLAGS  = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_TXPORT = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_RXPORT = 3'd4;

  localparam int TRIG_W      = 3;
  localparam int CTRL_RXFLSH = 0;
  localparam int CTRL_TXFLSH = 1;
  localparam int RXTRIG_LSB  = 2;
  localparam int TXTRIG_LSB  = 5;

  localparam int FLAG_RXREQ = 0;
  localparam int FLAG_TXREQ = 1;
  localparam int FLAG_RXUDF = 4;
  localparam int FLAG_TXOVF = 5;

  localparam int LEVEL_W = 4;

  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txFlush;
    logic rxFlush;
  } dpStrobe_t;
endpackage

// File: rtl/wfifo_wordq.sv
module wfifo_wordq #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign doPop  = pop && (count != '0);
  assign doPush = push && ((count != FULL_CNT) || doPop);
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R5: the occupancy never exceeds the depth
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R6: a flush leaves the queue empty on the next cycle
  p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0));
endmodule

// File: rtl/wfifo_dp.sv
module wfifo_dp
  import wfifo_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int DEPTH      = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strobe,
  input  logic [8*WORD_BYTES-1:0] swWrData,
  input  logic                   txByteTake,
  input  logic                   txLast,
  output logic [7:0]             txByte,
  output logic                   txByteValid,
  input  logic [7:0]             rxByte,
  input  logic                   rxByteValid,
  input  logic                   rxLast,
  output logic                   rxByteReady,
  output logic [$clog2(DEPTH+1)-1:0] txCount,
  output logic [$clog2(DEPTH+1)-1:0] rxCount,
  output logic [8*WORD_BYTES-1:0] rxHead
);
  localparam int DW = 8 * WORD_BYTES;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int LW = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam logic [LW-1:0] TOP_LANE = LW'(WORD_BYTES - 1);

  // transmit: unpack head word byte by byte
  logic [DW-1:0] txHead;
  logic [LW-1:0] txLane;
  logic txTake, txWordDone;

  assign txByteValid = (txCount != '0);
  assign txByte      = txHead[{txLane, 3'b000} +: 8];
  assign txTake      = txByteTake && txByteValid;
  assign txWordDone  = txTake && ((txLane == TOP_LANE) || txLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               txLane <= '0;
    else if (strobe.txFlush) txLane <= '0;
    else if (txTake)         txLane <= txWordDone ? '0 : txLane + 1'b1;
  end

  wfifo_wordq #(.WIDTH(DW), .DEPTH(DEPTH)) txQ_i (
    .clk(clk), .rstN(rstN), .flush(strobe.txFlush),
    .push(strobe.txPush), .pushData(swWrData),
    .pop(txWordDone), .head(txHead), .count(txCount)
  );

  // receive: pack bytes into a word
  logic [DW-1:0] rxAcc, rxWord;
  logic [LW-1:0] rxLane;
  logic rxAccept, rxWordDone;

  assign rxByteReady = (rxCount != CW'(DEPTH));
  assign rxAccept    = rxByteValid && rxByteReady;
  assign rxWord      = rxAcc | (DW'(rxByte) << {rxLane, 3'b000});
  assign rxWordDone  = rxAccept && ((rxLane == TOP_LANE) || rxLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxLane <= '0;
      rxAcc  <= '0;
    end else if (strobe.rxFlush) begin
      rxLane <= '0;
      rxAcc  <= '0;
    end else if (rxAccept) begin
      rxLane <= rxWordDone ? '0 : rxLane + 1'b1;
      rxAcc  <= rxWordDone ? '0 : rxWord;
    end
  end

  wfifo_wordq #(.WIDTH(DW), .DEPTH(DEPTH)) rxQ_i (
    .clk(clk), .rstN(rstN), .flush(strobe.rxFlush),
    .push(rxWordDone), .pushData(rxWord),
    .pop(strobe.rxPop), .head(rxHead), .count(rxCount)
  );

  // R3: a byte taken with the last marker restarts at lane zero
  p_tx_last_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txByteTake && txByteValid && txLast) |=> (txLane == '0));

  // R4: a completed receive word leaves the packing state empty
  p_rx_word_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rxByteValid && rxByteReady && rxLast) |=> (rxAcc == '0));
endmodule

// File: rtl/wfifo_ctrl.sv
module wfifo_ctrl
  import wfifo_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int DEPTH      = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic                   regRdEn,
  input  logic [REG_AW-1:0]      regAddr,
  input  logic [7:0]             ctrlWrData,
  output logic [8*WORD_BYTES-1:0] regRdData,
  input  logic [$clog2(DEPTH+1)-1:0] txCount,
  input  logic [$clog2(DEPTH+1)-1:0] rxCount,
  input  logic [8*WORD_BYTES-1:0] rxHead,
  output dpStrobe_t              strobe,
  output logic                   txDataReq,
  output logic                   rxDataReq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [TRIG_W-1:0] txTrig, rxTrig;
  logic txFlushPend, rxFlushPend, txOvf, rxUdf;
  logic [CW-1:0] txFree;
  logic wrCtrl, wrFlags, wrTxPort, rdRxPort;

  assign txFree   = CW'(DEPTH) - txCount;
  assign wrCtrl   = regWrEn && (regAddr == ADDR_CTRL);
  assign wrFlags  = regWrEn && (regAddr == ADDR_FLAGS);
  assign wrTxPort = regWrEn && (regAddr == ADDR_TXPORT);
  assign rdRxPort = regRdEn && (regAddr == ADDR_RXPORT);

  assign strobe.txPush  = wrTxPort && (txFree != '0);
  assign strobe.rxPop   = rdRxPort && (rxCount != '0);
  assign strobe.txFlush = txFlushPend;
  assign strobe.rxFlush = rxFlushPend;

  assign txDataReq = (int'(txFree)  >= int'(txTrig) + 1);
  assign rxDataReq = (int'(rxCount) >= int'(rxTrig) + 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txTrig <= '0; rxTrig <= '0;
      txFlushPend <= 1'b0; rxFlushPend <= 1'b0;
      txOvf <= 1'b0; rxUdf <= 1'b0;
    end else begin
      txFlushPend <= wrCtrl && ctrlWrData[CTRL_TXFLSH];
      rxFlushPend <= wrCtrl && ctrlWrData[CTRL_RXFLSH];
      if (wrCtrl) begin
        txTrig <= ctrlWrData[TXTRIG_LSB +: TRIG_W];
        rxTrig <= ctrlWrData[RXTRIG_LSB +: TRIG_W];
      end
      if (wrTxPort && (txFree == '0))         txOvf <= 1'b1;
      else if (wrFlags && ctrlWrData[FLAG_TXOVF]) txOvf <= 1'b0;
      if (rdRxPort && (rxCount == '0))        rxUdf <= 1'b1;
      else if (wrFlags && ctrlWrData[FLAG_RXUDF]) rxUdf <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdData[TXTRIG_LSB +: TRIG_W] = txTrig;
        regRdData[RXTRIG_LSB +: TRIG_W] = rxTrig;
        regRdData[CTRL_TXFLSH] = txFlushPend;
        regRdData[CTRL_RXFLSH] = rxFlushPend;
      end
      ADDR_LEVEL: begin
        regRdData[LEVEL_W +: LEVEL_W] = LEVEL_W'(txFree);
        regRdData[0 +: LEVEL_W]       = LEVEL_W'(rxCount);
      end
      ADDR_FLAGS: begin
        regRdData[FLAG_TXOVF] = txOvf;
        regRdData[FLAG_RXUDF] = rxUdf;
        regRdData[FLAG_TXREQ] = txDataReq;
        regRdData[FLAG_RXREQ] = rxDataReq;
      end
      ADDR_RXPORT: regRdData = (rxCount != '0) ? rxHead : '0;
      default: regRdData = '0;
    endcase
  end

  // R6: a flush bit returns to zero once its flush has run
  p_flush_self_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (txFlushPend && !(regWrEn && regAddr == ADDR_CTRL && ctrlWrData[CTRL_TXFLSH]))
      |=> !txFlushPend);

  // R9: writing into a full transmit queue raises the overflow flag
  p_ovf_sets_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_TXPORT && txCount == CW'(DEPTH)) |=> txOvf);

  // R9: the overflow flag holds until cleared by a write of one
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (txOvf && !(regWrEn && regAddr == ADDR_FLAGS && ctrlWrData[FLAG_TXOVF])) |=> txOvf);

  // R10: reading an empty receive queue raises the underflow flag
  p_udf_sets_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_RXPORT && rxCount == '0) |=> rxUdf);
endmodule

// File: rtl/word_fifo_pair.sv
module word_fifo_pair
  import wfifo_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int DEPTH      = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWrEn,
  input  logic                    regRdEn,
  input  logic [2:0]              regAddr,
  input  logic [8*WORD_BYTES-1:0] regWrData,
  output logic [8*WORD_BYTES-1:0] regRdData,
  output logic                    txDataReq,
  output logic                    rxDataReq,
  output logic [7:0]              txByte,
  output logic                    txByteValid,
  input  logic                    txByteTake,
  input  logic                    txLast,
  input  logic [7:0]              rxByte,
  input  logic                    rxByteValid,
  input  logic                    rxLast,
  output logic                    rxByteReady
);
  localparam int DW = 8 * WORD_BYTES;
  localparam int CW = $clog2(DEPTH + 1);

  dpStrobe_t strobe;
  logic [CW-1:0] txCount, rxCount;
  logic [DW-1:0] rxHead;

  wfifo_ctrl #(.WORD_BYTES(WORD_BYTES), .DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .ctrlWrData(regWrData[7:0]), .regRdData(regRdData),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead),
    .strobe(strobe), .txDataReq(txDataReq), .rxDataReq(rxDataReq)
  );

  wfifo_dp #(.WORD_BYTES(WORD_BYTES), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .swWrData(regWrData),
    .txByteTake(txByteTake), .txLast(txLast), .txByte(txByte),
    .txByteValid(txByteValid), .rxByte(rxByte), .rxByteValid(rxByteValid),
    .rxLast(rxLast), .rxByteReady(rxByteReady),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead)
  );
endmodule

// File: tb/word_fifo_pair_tb_top.sv
module word_fifo_pair_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic txDataReq, rxDataReq, txByteValid, rxByteReady;
  logic [7:0] txByte;
  logic txByteTake = 1'b0, txLast = 1'b0;
  logic [7:0] rxByte = '0;
  logic rxByteValid = 1'b0, rxLast = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit drainOn = 1'b0;

  logic [8:0]  txExp[$];
  logic [31:0] rxExp[$];
  logic [31:0] rxPart = '0;
  int rxPartN = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  word_fifo_pair dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .txDataReq(txDataReq), .rxDataReq(rxDataReq), .txByte(txByte),
    .txByteValid(txByteValid), .txByteTake(txByteTake), .txLast(txLast),
    .rxByte(rxByte), .rxByteValid(rxByteValid), .rxLast(rxLast),
    .rxByteReady(rxByteReady)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic chkReg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    regRead(a, d);
    chk(req, d, exp);
  endtask

  // driver: push a word and queue its expected bytes
  task automatic pushTx(input logic [31:0] w, input int nBytes, input bit expect_it);
    regWrite(3'd3, w);
    if (expect_it)
      for (int i = 0; i < nBytes; i++)
        txExp.push_back({(i == nBytes - 1), w[8*i +: 8]});
  endtask

  task automatic waitTxDrain();
    int guard = 0;
    while (txExp.size() != 0 && guard < 500) begin
      @(negedge clk); guard++;
    end
    @(negedge clk);
  endtask

  // driver for the receive byte side, with a packing model
  task automatic rxSend(input logic [7:0] b, input bit last);
    while (!rxByteReady) @(negedge clk);
    rxByte = b; rxLast = last; rxByteValid = 1'b1;
    rxPart[8*rxPartN +: 8] = b;
    rxPartN++;
    if (last || rxPartN == 4) begin
      rxExp.push_back(rxPart);
      rxPart = '0; rxPartN = 0;
    end
    @(negedge clk);
    rxByteValid = 1'b0; rxLast = 1'b0;
  endtask

  task automatic readRx(input string req);
    logic [31:0] d;
    logic [31:0] e;
    e = (rxExp.size() != 0) ? rxExp.pop_front() : 32'h0;
    regRead(3'd4, d);
    chk(req, d, e);
  endtask

  // monitor: consume transmit bytes and compare to the queue (R2, R3)
  always @(negedge clk) begin
    logic [8:0] e;
    if (!rstN || !drainOn) begin
      txByteTake = 1'b0; txLast = 1'b0;
    end else if (txByteValid) begin
      if (txExp.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: actual=unexpected byte %h expected=none", txByte);
        txByteTake = 1'b1; txLast = 1'b0;
      end else begin
        e = txExp.pop_front();
        chk("R2/R3 tx byte", {24'h0, txByte}, {24'h0, e[7:0]});
        txByteTake = 1'b1; txLast = e[8];
      end
    end else begin
      txByteTake = 1'b0; txLast = 1'b0;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chkReg("R1 ctrl", 3'd0, 32'h00);
    chkReg("R1 R5 level", 3'd1, 32'h80);
    chkReg("R1 flags", 3'd2, 32'h02);
    chk("R1 pins", {30'h0, txDataReq, rxDataReq}, 32'h2);

    // R2, R3: byte order, word order, short word in the middle
    drainOn = 1'b1;
    pushTx(32'h44332211, 4, 1'b1);
    pushTx(32'h88776655, 4, 1'b1);
    pushTx(32'hDEAD5A3C, 2, 1'b1);
    pushTx(32'hCCBBAA99, 4, 1'b1);
    pushTx(32'h000000F1, 1, 1'b1);
    pushTx(32'h04030201, 4, 1'b1);
    waitTxDrain();
    chk("R2 drained", {31'h0, txByteValid}, 32'h0);
    chkReg("R5 level empty", 3'd1, 32'h80);

    // R7 transmit trigger, R5 level
    drainOn = 1'b0;
    @(negedge clk);
    regWrite(3'd0, 32'hA0);
    pushTx(32'h1, 4, 1'b1);
    pushTx(32'h2, 4, 1'b1);
    chkReg("R7 req at free 6 trig 5", 3'd2, 32'h02);
    pushTx(32'h3, 4, 1'b1);
    chkReg("R7 req off at free 5", 3'd2, 32'h00);
    chk("R7 pin", {31'h0, txDataReq}, 32'h0);
    chkReg("R5 level tx free 5", 3'd1, 32'h50);

    // R9 overflow
    for (int i = 0; i < 5; i++) pushTx(32'h100 + i, 4, 1'b1);
    chkReg("R5 level full", 3'd1, 32'h00);
    pushTx(32'hBADBAD00, 4, 1'b0);
    chkReg("R9 ovf set", 3'd2, 32'h20);
    chkReg("R9 ovf held", 3'd2, 32'h20);
    regWrite(3'd2, 32'h20);
    chkReg("R9 ovf cleared", 3'd2, 32'h00);

    // R6 transmit flush
    regWrite(3'd0, 32'hA2);
    chkReg("R6 flush bit visible", 3'd0, 32'hA2);
    chkReg("R6 flush bit cleared trig kept", 3'd0, 32'hA0);
    chkReg("R6 tx emptied", 3'd1, 32'h80);
    txExp.delete();
    chkReg("R7 req after flush", 3'd2, 32'h02);
    drainOn = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 nothing left", {31'h0, txByteValid}, 32'h0);

    // R4, R8 receive packing and trigger
    regWrite(3'd0, 32'h04);
    rxSend(8'h11, 0); rxSend(8'h22, 0); rxSend(8'h33, 0); rxSend(8'h44, 0);
    chkReg("R8 rx req off at 1 trig 1", 3'd2, 32'h02);
    rxSend(8'h55, 0); rxSend(8'h66, 0); rxSend(8'h77, 1);
    chkReg("R8 rx req on at 2", 3'd2, 32'h03);
    chk("R8 pin", {31'h0, rxDataReq}, 32'h1);
    chkReg("R5 level rx 2", 3'd1, 32'h82);
    readRx("R4 full word");
    readRx("R4 short word zero fill");
    chkReg("R5 rx drained", 3'd1, 32'h80);

    // R10 underflow
    readRx("R10 empty read returns 0");
    chkReg("R10 udf set", 3'd2, 32'h12);
    chkReg("R10 count unchanged", 3'd1, 32'h80);
    regWrite(3'd2, 32'h10);
    chkReg("R10 udf cleared", 3'd2, 32'h02);

    // R6 receive flush clears words and partial packing
    rxSend(8'hA1, 0); rxSend(8'hA2, 0); rxSend(8'hA3, 0); rxSend(8'hA4, 0);
    rxSend(8'hE1, 0); rxSend(8'hE2, 0);
    regWrite(3'd0, 32'h05);
    chkReg("R6 rx flush bit visible", 3'd0, 32'h05);
    chkReg("R6 rx emptied tx untouched", 3'd1, 32'h80);
    chkReg("R6 rx trig kept", 3'd0, 32'h04);
    rxExp.delete(); rxPart = '0; rxPartN = 0;
    rxSend(8'hC1, 0); rxSend(8'hC2, 0); rxSend(8'hC3, 0); rxSend(8'hC4, 0);
    readRx("R6 R4 packing restarted");

    // R11 back-pressure at full
    for (int i = 0; i < 32; i++) rxSend(8'(i + 8'h20), 0);
    chk("R11 not ready at full", {31'h0, rxByteReady}, 32'h0);
    chkReg("R5 level rx full", 3'd1, 32'h88);
    for (int i = 0; i < 8; i++) readRx("R4 R11 ordered read");
    chk("R11 ready again", {31'h0, rxByteReady}, 32'h1);
    chkReg("R5 level final", 3'd1, 32'h80);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule